// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave on a four-wire serial control bus (clock, active-low select, data in, data out). A controller shifts in an address byte, optionally followed by a data byte, to write or read back one register of a bank of 8-bit configuration registers. Every address byte also carries a power bit, which the block keeps as a power-down state. The whole bank appears on a parallel output for the rest of the chip, and one bit of register 1 drives a general-purpose latch pin in inverted sense.

The serial clock is unrelated to the system clock. The block passes the serial clock, the select and the data input through synchronizer flops into the system clock domain and finds the serial clock edges there. Both serial clock levels must therefore last several system clock periods. A four-state machine does the decoding. `ST_ADDR` collects the address byte. After an address byte with the follow flag clear, the transition *cmd_done* stays in `ST_ADDR`. With the follow flag set, *go_write* leads to `ST_WDATA` and *go_read* leads to `ST_RDATA`. A finished data byte takes *byte2_done* to `ST_HOLD`, and `ST_HOLD` takes *release* back to `ST_ADDR` when select rises. If select rises in the middle of a byte in any state, *abort* returns the machine to `ST_ADDR`. When select rises between bytes in `ST_WDATA` or `ST_RDATA`, the state is kept, so the data byte may come in a later select window.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, `pwr_down` is 1, every register holds its `RESET_VAL` byte (register i at bits 8i+7..8i), and `sdo_oe` is 0.
- R2: Each complete address byte copies its bit 7 into `pwr_down` (1 = powered down). An address byte with bit 1 clear is a complete command, and the next byte is taken as a new address byte.
- R3: An address byte has bits 6..3 as the register number, bit 2 as 0 for a write, and bit 1 as 1. After it, the next 8 serial clocks in the same select window write that register, MSB first, with data sampled on rising serial clock edges. The register changes only once the eighth bit is in.
- R4: The data byte of a write may come in a second select window. The register stays unchanged until that byte completes.
- R5: An address byte with bit 2 set and bit 1 set starts a read. During the next 8 serial clocks, in the same window or in the next one, `sdo` presents the register MSB first. Each new bit appears after a falling serial clock edge, and bit 7 is present before the first rising edge.
- R6: `sdo_oe` is 0 whenever select is high, and 1 while select is low during a read data byte.
- R7: Register 3 is write-only. Writes reach its parallel output, but a read of it returns 0x00.
- R8: Register numbers 12 to 15 (14 being a reserved test number) are inaccessible. Writes to them change no register, and reads of them return 0x00.
- R9: `latch_out` is the inverse of register 1 bit 0.
- R10: If select rises in the middle of a byte, that byte is discarded and the next byte is decoded as an address byte.
- R11: Serial clocks that follow a completed data byte before select rises are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial control clock, asynchronous |
| sel_n | input | 1 | Active-low serial select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the external tri-state driver of `sdo` |
| pwr_down | output | 1 | Power-down state, 1 = down |
| latch_out | output | 1 | Latch pin, inverse of register 1 bit 0 |
| regs_flat | output | NUM_REGS*8 | All registers, register i at bits 8i+7..8i |

## Verification
The bench keeps the default bank of twelve registers and two synchronizer stages. It overrides `RESET_VAL` with a distinct byte per register, so a single comparison shows any stray write or a wrong reset value. That reset pattern sets register 1 bit 0, which means the latch pin starts at 0 and the inversion can be seen from the first check. The serial clock half period is ten system clocks, so every edge clears the synchronizer. This allows reads to be sampled bit by bit, and lets aborted bytes stop at exact bit positions.

// File: rtl/ctl_sp_pkg.sv
package ctl_sp_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int NUM_W    = 4;
    // address byte field positions (decoded by the controller side too)
    localparam int PWR_BIT  = 7;
    localparam int NUM_HI   = 6;
    localparam int NUM_LO   = 3;
    localparam int RD_BIT   = 2;
    localparam int MORE_BIT = 1;

    typedef enum logic [1:0] {
        ST_ADDR  = 2'd0,
        ST_WDATA = 2'd1,
        ST_RDATA = 2'd2,
        ST_HOLD  = 2'd3
    } sp_state_t;
endpackage

// File: rtl/ctl_sp_sync.sv
module ctl_sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sel_n_in,
    input  logic sdi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_s,
    output logic sdi_s
);
    logic [STAGES-1:0] sclk_p, sel_p, sdi_p;
    logic              sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            sel_p  <= '1;
            sdi_p  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk_in};
            sel_p  <= {sel_p[STAGES-2:0], sel_n_in};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi_in};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
    assign sel_s     = sel_p[STAGES-1];
    assign sdi_s     = sdi_p[STAGES-1];
endmodule

// File: rtl/ctl_sp_bank.sv
module ctl_sp_bank #(
    parameter int                        NUM_REGS  = 12,
    parameter int                        DATA_W    = 8,
    parameter int                        IDX_W     = 4,
    parameter int                        WO_IDX    = 3,
    parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= RESET_VAL[g*DATA_W +: DATA_W];
            else if (wr_en && wr_idx == IDX_W'(g))
                regs[g] <= wr_data;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i) && i != WO_IDX)
                rd_data = regs[i];
        end
    end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_sp_pkg::*;
#(
    parameter int                        NUM_REGS    = 12,
    parameter int                        SYNC_STAGES = 2,
    parameter int                        WO_IDX      = 3,
    parameter int                        LATCH_REG   = 1,
    parameter logic [NUM_REGS*BYTE_W-1:0] RESET_VAL  = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_in,
    input  logic                       sel_n,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic                       pwr_down,
    output logic                       latch_out,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    localparam int DATA_W = BYTE_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_rise, sclk_fall, sel_s, sdi_s;
    sp_state_t         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] shreg;
    logic [DATA_W-1:0] new_byte, rd_sh, rd_data;
    logic [NUM_W-1:0]  num_q;
    logic              pwr_q, byte_done, wr_en;

    ctl_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .sel_n_in (sel_n),
        .sdi_in   (sdi),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sel_s    (sel_s),
        .sdi_s    (sdi_s)
    );

    assign new_byte  = {shreg, sdi_s};
    assign byte_done = sclk_rise && !sel_s && bit_cnt == LAST_BIT;
    assign wr_en     = (state_q == ST_WDATA) && byte_done;

    ctl_sp_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (NUM_W),
        .WO_IDX   (WO_IDX),
        .RESET_VAL(RESET_VAL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (num_q),
        .wr_data  (new_byte),
        .rd_idx   (new_byte[NUM_HI:NUM_LO]),
        .rd_data  (rd_data),
        .regs_flat(regs_flat)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ADDR: begin
                if (byte_done && new_byte[MORE_BIT])
                    state_d = new_byte[RD_BIT] ? ST_RDATA : ST_WDATA;  // go_read / go_write
            end
            ST_WDATA: if (byte_done) state_d = ST_HOLD;                 // byte2_done
            ST_RDATA: if (byte_done) state_d = ST_HOLD;                 // byte2_done
            ST_HOLD:  if (sel_s)     state_d = ST_ADDR;                 // release
        endcase
        if (sel_s && bit_cnt != '0)
            state_d = ST_ADDR;                                          // abort
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            num_q   <= '0;
            pwr_q   <= 1'b1;
            rd_sh   <= '0;
        end else begin
            if (sel_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise && state_q != ST_HOLD) begin
                shreg   <= new_byte[DATA_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state_q == ST_ADDR && byte_done) begin
                pwr_q <= new_byte[PWR_BIT];
                num_q <= new_byte[NUM_HI:NUM_LO];
                if (new_byte[MORE_BIT] && new_byte[RD_BIT])
                    rd_sh <= rd_data;
            end else if (state_q == ST_RDATA && sclk_fall && !sel_s && bit_cnt != '0) begin
                rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign sdo_oe    = !sel_s && state_q == ST_RDATA;
    assign sdo       = sdo_oe & rd_sh[DATA_W-1];
    assign pwr_down  = pwr_q;
    assign latch_out = ~regs_flat[LATCH_REG*DATA_W];
endmodule

// File: rtl/ctl_sp_checker.sv
module ctl_sp_checker
    import ctl_sp_pkg::*;
#(
    parameter int REGS_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              pwr_down,
    input logic [REGS_W-1:0] regs_flat,
    input sp_state_t         state_q,
    input logic              sclk_rise,
    input logic              sclk_fall
);
    // R6: select high for the whole synchronizer depth keeps the driver off
    a_r6_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && $past(sel_n) && $past(sel_n, 2)) |-> !sdo_oe);

    // R2: power state moves only on a finished address byte
    a_r2_pwr_on_address: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_down) |-> ($past(state_q) == ST_ADDR && $past(sclk_rise)));

    // R3 / R8 / R11: the bank changes only at the end of a write data byte
    a_r3_write_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> ($past(state_q) == ST_WDATA && $past(sclk_rise)));

    // R5: read data moves only after a falling serial clock edge
    a_r5_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && $past(state_q) == ST_RDATA && !$stable(sdo))
            |-> $past(sclk_fall));
endmodule

bind ctl_serial_port ctl_sp_checker #(.REGS_W(NUM_REGS*BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .pwr_down (pwr_down),
    .regs_flat(regs_flat),
    .state_q  (state_q),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall)
);

// File: tb/tb_ctl_serial_port.sv
module tb_ctl_serial_port;
    localparam int NR = 12;
    localparam logic [NR*8-1:0] RV = 96'h1B1A_1918_1716_1514_1312_1110;
    localparam time HP = 40ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk_in = 1'b0, sel_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe, pwr_down, latch_out;
    logic [NR*8-1:0] regs_flat;

    int errors = 0, checks = 0;
    logic [7:0] exp_r [NR];
    logic exp_pwr;
    bit finished = 0;

    ctl_serial_port #(.NUM_REGS(NR), .RESET_VAL(RV)) dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sel_n(sel_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down), .latch_out(latch_out),
        .regs_flat(regs_flat)
    );

    always #2ns clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        logic [NR*8-1:0] e;
        for (int i = 0; i < NR; i++) e[i*8 +: 8] = exp_r[i];
        checks++;
        if (regs_flat !== e) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, regs_flat, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic sel_on();
        sel_n = 1'b0; #HP;
    endtask

    task automatic sel_off();
        sclk_in = 1'b0; #HP; sel_n = 1'b1; #(2*HP);
    endtask

    task automatic bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sclk_in = 1'b0; sdi = v[i]; #HP;
            sclk_in = 1'b1; #HP;
        end
    endtask

    task automatic addr_byte(input logic [7:0] a);
        bits(a, 8);
        exp_pwr = a[7];
    endtask

    task automatic rd_byte(output logic [7:0] v, output logic oe_all);
        oe_all = 1'b1;
        sdi = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sclk_in = 1'b0; #HP;
            v[i] = sdo; oe_all &= sdo_oe;
            sclk_in = 1'b1; #HP;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sel_on(); addr_byte(a); bits(d, 8); sel_off();
    endtask

    task automatic t_reset();
        for (int i = 0; i < NR; i++) exp_r[i] = RV[i*8 +: 8];
        exp_pwr = 1'b1;
        chk("R1 pwr_down", pwr_down, 1);
        chk_regs("R1 regs");
        chk("R1 sdo_oe", sdo_oe, 0);
        chk("R9 latch at reset", latch_out, 0);
    endtask

    task automatic t_power_single();
        sel_on();
        addr_byte(8'h80); #HP;
        chk("R2 single down", pwr_down, 1);
        addr_byte(8'h00); #HP;
        chk("R2 single up then next byte is address", pwr_down, 0);
        sel_off();
        chk_regs("R2 regs untouched");
    endtask

    task automatic t_write_contig();
        wr(8'h2A, 8'hA5); exp_r[5] = 8'hA5;
        chk_regs("R3 contiguous write");
        chk("R2 pwr after write", pwr_down, exp_pwr);
    endtask

    task automatic t_write_split();
        sel_on(); addr_byte(8'h12); sel_off();
        chk_regs("R4 unchanged after address window");
        sel_on(); bits(8'h3C, 8); sel_off();
        exp_r[2] = 8'h3C;
        chk_regs("R4 split write");
    endtask

    task automatic t_read_contig();
        logic [7:0] v; logic oe;
        sel_on(); addr_byte(8'h2E); rd_byte(v, oe); sel_off();
        chk("R5 contiguous read", v, 8'hA5);
        chk("R6 oe during read", oe, 1);
    endtask

    task automatic t_read_split();
        logic [7:0] v; logic oe;
        sel_on(); addr_byte(8'h16); sel_off();
        chk("R6 oe between windows", sdo_oe, 0);
        sel_on(); rd_byte(v, oe); sel_off();
        chk("R5 split read", v, 8'h3C);
        chk("R6 oe after read", sdo_oe, 0);
    endtask

    task automatic t_write_only();
        logic [7:0] v; logic oe;
        wr(8'h9A, 8'h77); exp_r[3] = 8'h77;
        chk_regs("R7 write-only reg stored");
        chk("R2 power bit in write address", pwr_down, 1);
        sel_on(); addr_byte(8'h1E); rd_byte(v, oe); sel_off();
        chk("R7 write-only reads zero", v, 8'h00);
    endtask

    task automatic t_holes();
        logic [7:0] v; logic oe;
        wr(8'h62, 8'hFF); wr(8'h6A, 8'hFF); wr(8'h72, 8'hFF); wr(8'h7A, 8'hFF);
        chk_regs("R8 writes to 12..15 ignored");
        sel_on(); addr_byte(8'h76); rd_byte(v, oe); sel_off();
        chk("R8 read of 14 is zero", v, 8'h00);
    endtask

    task automatic t_latch();
        wr(8'h0A, 8'h00); exp_r[1] = 8'h00;
        chk("R9 latch after 0", latch_out, 1);
        wr(8'h0A, 8'h01); exp_r[1] = 8'h01;
        chk("R9 latch after 1", latch_out, 0);
        chk_regs("R9 regs");
    endtask

    task automatic t_abort();
        sel_on(); bits(8'hFF, 4); sel_off();
        wr(8'h2A, 8'h5A); exp_r[5] = 8'h5A;
        chk_regs("R10 abort in address byte");
        sel_on(); addr_byte(8'h32); bits(8'hFF, 4); sel_off();
        sel_on(); addr_byte(8'h80); #HP;
        chk("R10 next byte decoded as address", pwr_down, 1);
        addr_byte(8'h00); sel_off();
        chk_regs("R10 aborted data byte dropped");
    endtask

    task automatic t_trailing();
        sel_on(); addr_byte(8'h2A); bits(8'h11, 8); bits(8'hFF, 8); sel_off();
        exp_r[5] = 8'h11;
        chk("R11 trailing clocks ignored", pwr_down, 0);
        chk_regs("R11 regs");
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        #20ns rst_n = 1'b1;
        #40ns;
        t_reset();
        t_power_single();
        t_write_contig();
        t_write_split();
        t_read_contig();
        t_read_split();
        t_write_only();
        t_holes();
        t_latch();
        t_abort();
        t_trailing();
        finish_run();
    end
endmodule